// File: doc/BRIEF.md
# DMA Page-Table Address Translator

This block turns a 32-bit device-side DMA address into a physical address. It uses a flat, single-level page table kept in system memory. It serves one translation at a time. The address arrives on a request channel, and the block first checks its page index against a table-size register. If the index is in range, the block reads the page's frame word from memory and returns the physical address with a permission bit. If the index is out of range, or the memory read fails, the block returns a fault.

Pages are 4096 bytes, so the page index is the request address shifted right by 12. Each table entry is 8 bytes: the frame word is at byte 0 and a second word at byte 4 is never read. The size register holds the table length in bytes, not in entries. The base register is used with its most significant bit forced to zero.

Back-pressure rules:
- The request channel accepts a request only while no translation is in progress.
- The response channel holds its data unchanged until the consumer raises ready.
- The memory read request holds its address until memory raises ready.
- The memory answer comes back as a single-cycle valid pulse with an error flag.

Top module: `dma_pt_xlate`

## Requirements
- R1: After reset the request channel is ready, no response or memory request is pending, and both the base and the size register read back zero.
- R2: If the page index (request address bits 31:12) is not strictly below the size register divided by 8, the response has permission 0 and address 0, and no memory read is issued. This includes an index exactly equal to size/8 and any size below 8.
- R3: For an in-range request, exactly one memory read is issued. Its address is the base register with bit 31 cleared, plus 8 times the page index, modulo 2^32.
- R4: On an error-free memory answer, the response has permission 1 and address {frame[31:12], request[11:0]}.
- R5: On a memory answer with the error flag set, the response has permission 0 and address 0.
- R6: The request channel is ready only while idle, so only one translation is in flight. A response stays valid and unchanged until it is accepted with rsp_ready.
- R7: A memory read request stays valid with a stable address until mem_req_ready is seen.
- R8: A register write with select code 2 (invalidate) is accepted but changes neither register and has no effect on later translations.
- R9: Register select codes are 0 = table base and 1 = table size. Both are writable and readable through cfg_rdata. Codes 2 and 3 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 32 | Device-side DMA address |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer accepts the result |
| rsp_addr | output | 32 | Physical address, zero on fault |
| rsp_perm | output | 1 | 1 = read/write granted, 0 = fault |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 base, 1 size, 2 invalidate) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| mem_req_valid | output | 1 | Frame-word read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_data | input | 32 | Frame word |
| mem_rsp_err | input | 1 | Read failed |

## Verification
Random requests use page indices spread just below, at and above size/8. This separates an off-by-one in the bounds compare from a correct one, and a size treated as an entry count from one treated as a byte length. Random bases, some with bit 31 set, together with indices near a carry boundary, test the entry-address arithmetic. Memory latencies and ready patterns are random, and an error flag appears on a fixed subset of entry addresses, so that success and error results are told apart. Directed cases cover a zero-size table, invalidate writes placed between translations, and long response back-pressure.

// File: rtl/dma_pt_xlate_pkg.sv
package dma_pt_xlate_pkg;
  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_FETCH = 2'd1,
    XS_WAIT  = 2'd2,
    XS_RESP  = 2'd3
  } xlate_state_t;

  localparam logic [1:0] SEL_BASE  = 2'd0;
  localparam logic [1:0] SEL_SIZE  = 2'd1;
  localparam logic [1:0] SEL_INVAL = 2'd2;
endpackage

// File: rtl/dma_pt_cfg_regs.sv
module dma_pt_cfg_regs #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  output logic [ADDR_W-1:0] tbl_base,
  output logic [ADDR_W-1:0] tbl_size
);
  import dma_pt_xlate_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_base <= '0;
      tbl_size <= '0;
    end else if (cfg_we) begin
      // Select code 2 (invalidate) and code 3 fall through with no effect.
      if (cfg_sel == SEL_BASE) tbl_base <= cfg_wdata;
      if (cfg_sel == SEL_SIZE) tbl_size <= cfg_wdata;
    end
  end

  always_comb begin
    case (cfg_sel)
      SEL_BASE: cfg_rdata = tbl_base;
      SEL_SIZE: cfg_rdata = tbl_size;
      default:  cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_pt_entry_calc.sv
module dma_pt_entry_calc #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENT_LOG2  = 3
) (
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [ADDR_W-1:0] tbl_size,
  output logic              in_bounds,
  output logic [ADDR_W-1:0] entry_addr
);
  localparam int IDX_W = ADDR_W - PAGE_BITS;

  logic [IDX_W-1:0]  page_idx;
  logic [ADDR_W-1:0] idx_ext;
  logic [ADDR_W-1:0] entry_cnt;
  logic [ADDR_W-1:0] base_clr;

  assign page_idx  = in_addr[ADDR_W-1:PAGE_BITS];
  assign idx_ext   = {{PAGE_BITS{1'b0}}, page_idx};
  assign entry_cnt = tbl_size >> ENT_LOG2;
  assign in_bounds = idx_ext < entry_cnt;
  assign base_clr  = {1'b0, tbl_base[ADDR_W-2:0]};
  assign entry_addr = base_clr + (idx_ext << ENT_LOG2);
endmodule

// File: rtl/dma_pt_xlate.sv
module dma_pt_xlate #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENT_LOG2  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_perm,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_err
);
  import dma_pt_xlate_pkg::*;

  xlate_state_t         state;
  logic [ADDR_W-1:0]    tbl_base, tbl_size;
  logic                 calc_inb;
  logic [ADDR_W-1:0]    calc_entry;
  logic [PAGE_BITS-1:0] page_off;
  logic [ADDR_W-1:0]    entry_q;

  dma_pt_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .tbl_base(tbl_base), .tbl_size(tbl_size)
  );

  dma_pt_entry_calc #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .ENT_LOG2(ENT_LOG2)) u_calc (
    .in_addr(req_addr), .tbl_base(tbl_base), .tbl_size(tbl_size),
    .in_bounds(calc_inb), .entry_addr(calc_entry)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= XS_IDLE;
      page_off <= '0;
      entry_q  <= '0;
      rsp_addr <= '0;
      rsp_perm <= 1'b0;
    end else begin
      case (state)
        XS_IDLE: if (req_valid) begin
          page_off <= req_addr[PAGE_BITS-1:0];
          entry_q  <= calc_entry;
          if (calc_inb) begin
            state <= XS_FETCH;
          end else begin
            rsp_addr <= '0;
            rsp_perm <= 1'b0;
            state    <= XS_RESP;
          end
        end
        XS_FETCH: if (mem_req_ready) state <= XS_WAIT;
        XS_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            rsp_addr <= '0;
            rsp_perm <= 1'b0;
          end else begin
            rsp_addr <= {mem_rsp_data[ADDR_W-1:PAGE_BITS], page_off};
            rsp_perm <= 1'b1;
          end
          state <= XS_RESP;
        end
        XS_RESP: if (rsp_ready) state <= XS_IDLE;
        default: state <= XS_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == XS_IDLE);
  assign mem_req_valid = (state == XS_FETCH);
  assign mem_req_addr  = entry_q;
  assign rsp_valid     = (state == XS_RESP);
endmodule

// File: rtl/dma_pt_xlate_chk.sv
module dma_pt_xlate_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic              rsp_perm,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr
);
  a_r6_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_perm));

  a_r6_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && !mem_req_valid);

  a_r7_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r5_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_perm |-> rsp_addr == '0);
endmodule

bind dma_pt_xlate dma_pt_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_perm(rsp_perm),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr)
);

// File: tb/dma_pt_xlate_tb_top.sv
module dma_pt_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_ready = 1'b0, rsp_perm;
  logic [31:0] rsp_addr;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0, fails = 0;
  logic [31:0] m_base = '0, m_size = '0, exp_entry = '0;
  int mem_seen = 0;

  always #2 clk = ~clk;

  dma_pt_xlate dut_i (.*);

  function automatic logic [31:0] frame_of(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic err_of(logic [31:0] a);
    return a[5:3] == 3'd5;
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // memory model: random ready, random latency, one-cycle answer
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_req_ready = 1'($urandom % 2);
      if (mem_req_valid && mem_req_ready) begin
        mem_seen++;
        chk("R3 entry addr", mem_req_addr, exp_entry);
        repeat (1 + ($urandom % 3)) begin
          @(negedge clk);
          mem_req_ready = 1'b0;
        end
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = frame_of(mem_req_addr);
        mem_rsp_err   = err_of(mem_req_addr);
      end
    end
  end

  task automatic cfg_write(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 2'd0) m_base = d;
    if (sel == 2'd1) m_size = d;
  endtask

  task automatic cfg_read(logic [1:0] sel, string rq, logic [31:0] exp);
    @(negedge clk);
    cfg_sel = sel;
    #1;
    chk(rq, cfg_rdata, exp);
  endtask

  task automatic xlate(logic [31:0] a, int hold);
    logic [31:0] idx, ent, e_addr;
    logic inb, e_perm;
    string tag;
    idx = {12'd0, a[31:12]};
    inb = idx < (m_size >> 3);
    ent = {1'b0, m_base[30:0]} + (idx << 3);
    exp_entry = ent;
    mem_seen = 0;
    if (!inb) begin e_addr = 0; e_perm = 0; tag = "R2 oob"; end
    else if (err_of(ent)) begin e_addr = 0; e_perm = 0; tag = "R5 memerr"; end
    else begin e_addr = {frame_of(ent)[31:12], a[11:0]}; e_perm = 1; tag = "R4 ok"; end
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 busy", {31'd0, req_ready}, 32'd0);
    forever begin
      rsp_ready = (hold > 0) ? 1'b0 : 1'($urandom % 2);
      if (hold > 0) hold--;
      if (rsp_valid && rsp_ready) break;
      @(negedge clk);
    end
    chk({tag, " addr"}, rsp_addr, e_addr);
    chk({tag, " perm"}, {31'd0, rsp_perm}, {31'd0, e_perm});
    chk(inb ? "R3 R7 one read" : "R2 no read", mem_seen, inb ? 1 : 0);
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    cfg_read(2'd0, "R1 base", 32'd0);
    cfg_read(2'd1, "R1 size", 32'd0);
    // R2 zero-size table
    xlate(32'h0000_0123, 0);
    // R9 register map
    cfg_write(2'd0, 32'h8001_0000);
    cfg_write(2'd1, 32'd100);            // 12 entries
    cfg_read(2'd0, "R9 base", 32'h8001_0000);
    cfg_read(2'd1, "R9 size", 32'd100);
    cfg_read(2'd3, "R9 sel3", 32'd0);
    // R2 boundary: index 11 in, index 12 out
    xlate(32'h0000_BABC, 0);
    xlate(32'h0000_C000, 0);
    // R5 directed error entry: base 0x10000 + 8*5 -> bits 5:3 = 5
    xlate(32'h0000_5FFF, 0);
    // R8 invalidate ignored
    cfg_write(2'd2, 32'hFFFF_FFFF);
    cfg_read(2'd0, "R8 base kept", 32'h8001_0000);
    cfg_read(2'd1, "R8 size kept", 32'd100);
    cfg_read(2'd2, "R9 sel2", 32'd0);
    xlate(32'h0000_2345, 6);              // R6 long back-pressure
    // size below 8 -> everything out of range
    cfg_write(2'd1, 32'd7);
    xlate(32'h0000_0000, 0);
    // carry-boundary base
    cfg_write(2'd0, 32'hFFFF_FFF8);
    cfg_write(2'd1, 32'hFFFF_FFFF);
    xlate(32'h0000_1ABC, 0);
    xlate(32'hFFFF_F001, 0);
    // random
    for (int i = 0; i < 300; i++) begin
      logic [31:0] ents, a;
      if (i % 20 == 0) begin
        cfg_write(2'd0, $urandom);
        cfg_write(2'd1, ($urandom % 64) * 8 + ($urandom % 8));
        if (i % 60 == 0) cfg_write(2'd2, $urandom);
      end
      ents = m_size >> 3;
      a = {(ents + 32'($urandom % 5) - 32'd2), 12'd0} | ($urandom % 4096);
      xlate(a, $urandom % 3);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule